// File: doc/BRIEF.md
# Clock Generator Configuration Arbiter with Aligned Divider Restart

This block sits in front of the output dividers of a four-bank clock generator. It decides where each configurable function gets its settings. There are five such functions: the feedback setting and the divider-and-enable setting of each of the four banks. Each one takes its settings either from a 2-bit strap code on pins or from software registers. After reset every function follows its pins. Software can move any single function over to register control by setting that function's own ownership bit.

Software writes new divider values into shadow registers through a small write/read port, which stands in for a serial interface. Those values stay pending until software writes the init command. That command copies every pending value into the active dividers and restarts all four bank dividers on the same reference edge. Each bank drives one divided clock onto all of its outputs. Under register control, a bank can be gated off without producing a clipped pulse.

Top module: `clkcfg_arbiter`

## Requirements
- R1: After reset the ownership register (address 0) reads 0, so every function follows its pins. The enable register (address 1) reads 0xF. Every shadow divider reads 1.
- R2: Ownership bits at address 0 are bit 0 for the feedback setting and bits 1, 2, 3 and 4 for banks A, B, C and D. Setting one bit moves only that function to register control.
- R3: A function uses exactly one source. Under register control, changes to its pin code have no effect. Under pin control, its shadow register and the init command have no effect on its divisor.
- R4: Under pin control with code c, bank divisors are BASE<<c (A: 1, B: 2, C: 3, D: 5). The feedback output `fb_div` equals 4<<c.
- R5: A bank with divisor N drives a clock that toggles every N reference edges, giving a period of 2N. All outputs of the bank carry the same value.
- R6: When reset is released, all bank clocks are low and each one first rises on reference edge N after release.
- R7: A value written to a shadow register (feedback at address 2, banks A to D at addresses 3 to 6) has no effect until the init command. A register-owned function uses its last loaded active value.
- R8: Writing 1 to bit 0 of address 7 loads every shadow value into the active registers one edge later. On that same edge it forces every bank clock low and restarts it, so each bank then first rises N edges later. Address 7 always reads 0, and without a write the init command never asserts.
- R9: Under pin control, a change in a bank's pin code reloads that bank's divisor and restarts that bank's divider on the next edge.
- R10: A loaded divider value of 0 acts as divide-by-1.
- R11: A register-owned bank is gated by its bit in the enable register (bits 0 to 3 for A to D). Clearing it lets the current high phase run its full length, and the outputs then stay low. Setting it again resumes with full-width pulses. A pin-owned bank is always enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DIV_W | Register write data |
| reg_rdata | output | DIV_W | Register read data for reg_addr |
| pin_fb | input | 2 | Strap code for the feedback setting |
| pin_a | input | 2 | Strap code for bank A |
| pin_b | input | 2 | Strap code for bank B |
| pin_c | input | 2 | Strap code for bank C |
| pin_d | input | 2 | Strap code for bank D |
| fb_div | output | DIV_W | Selected feedback setting |
| q_a | output | WA | Bank A outputs |
| q_b | output | WB | Bank B outputs |
| q_c | output | WC | Bank C outputs |
| q_d | output | WD | Bank D outputs |

## Verification
The assertions check the following on every cycle:
- the init command asserts only after a write;
- every bank is low on the edge that follows an init;
- a pin-code change restarts a pin-owned bank;
- a register-owned feedback setting changes only on init;
- a disabled bank that has gone low stays low.

Only the bench scenarios can show the actual divisor tables, the 2N periods, the alignment of first rising edges after reset and after init, and that pending values stay invisible before init. The same applies to the zero-as-one rule and to the full-length last high pulse when a bank is disabled.

// File: rtl/clkcfg_arbiter.sv
module clkcfg_arbiter #(
  parameter int DIV_W   = 8,
  parameter int BASE_A  = 1,
  parameter int BASE_B  = 2,
  parameter int BASE_C  = 3,
  parameter int BASE_D  = 5,
  parameter int FB_BASE = 4,
  parameter int WA      = 4,
  parameter int WB      = 4,
  parameter int WC      = 2,
  parameter int WD      = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DIV_W-1:0] reg_wdata,
  output logic [DIV_W-1:0] reg_rdata,
  input  logic [1:0]       pin_fb,
  input  logic [1:0]       pin_a,
  input  logic [1:0]       pin_b,
  input  logic [1:0]       pin_c,
  input  logic [1:0]       pin_d,
  output logic [DIV_W-1:0] fb_div,
  output logic [WA-1:0]    q_a,
  output logic [WB-1:0]    q_b,
  output logic [WC-1:0]    q_c,
  output logic [WD-1:0]    q_d
);
  localparam int NB = 4;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  function automatic logic [DIV_W-1:0] pin_div(input int b, input logic [1:0] c);
    int base;
    case (b)
      0: base = BASE_A;
      1: base = BASE_B;
      2: base = BASE_C;
      3: base = BASE_D;
      default: base = FB_BASE;
    endcase
    return DIV_W'(base << c);
  endfunction

  function automatic logic [DIV_W-1:0] nz(input logic [DIV_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [NB:0]               ctl_q;
  logic [NB-1:0]             en_q;
  logic                      init_q;
  logic [DIV_W-1:0]          fb_sh, fb_act;
  logic [NB-1:0][DIV_W-1:0]  sh, act;
  logic [NB-1:0][1:0]        pins;
  logic [NB-1:0]             bclk;

  assign pins = {pin_d, pin_c, pin_b, pin_a};

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      en_q   <= '1;
      init_q <= 1'b0;
      fb_sh  <= ONE;
      fb_act <= ONE;
      sh     <= {NB{ONE}};
      act    <= {NB{ONE}};
    end else begin
      init_q <= reg_we && reg_addr == 3'd7 && reg_wdata[0];
      if (reg_we) begin
        case (reg_addr)
          3'd0: ctl_q <= reg_wdata[NB:0];
          3'd1: en_q  <= reg_wdata[NB-1:0];
          3'd2: fb_sh <= reg_wdata;
          3'd3: sh[0] <= reg_wdata;
          3'd4: sh[1] <= reg_wdata;
          3'd5: sh[2] <= reg_wdata;
          3'd6: sh[3] <= reg_wdata;
          default: ;
        endcase
      end
      if (init_q) begin
        fb_act <= fb_sh;
        act    <= sh;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = DIV_W'(ctl_q);
      3'd1: reg_rdata = DIV_W'(en_q);
      3'd2: reg_rdata = fb_sh;
      3'd3: reg_rdata = sh[0];
      3'd4: reg_rdata = sh[1];
      3'd5: reg_rdata = sh[2];
      3'd6: reg_rdata = sh[3];
      default: reg_rdata = '0;
    endcase
  end

  assign fb_div = ctl_q[0] ? nz(fb_act) : pin_div(NB, pin_fb);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DIV_W-1:0] n, cnt;
    logic [1:0]       pc;
    logic             ph, gate;
    wire reg_own = ctl_q[b+1];
    wire restart = init_q || (!reg_own && pins[b] != pc);

    assign n = reg_own ? nz(act[b]) : pin_div(b, pins[b]);

    always_ff @(posedge clk_ref) begin
      if (!rst_n) begin
        cnt  <= '0;
        ph   <= 1'b0;
        gate <= 1'b1;
        pc   <= pins[b];
      end else begin
        pc <= pins[b];
        if (restart) begin
          cnt <= '0;
          ph  <= 1'b0;
        end else if (cnt >= n - ONE) begin
          cnt <= '0;
          ph  <= ~ph;
        end else begin
          cnt <= cnt + ONE;
        end
        if (!ph) gate <= reg_own ? en_q[b] : 1'b1;
      end
    end

    assign bclk[b] = ph & gate;
  end

  assign q_a = {WA{bclk[0]}};
  assign q_b = {WB{bclk[1]}};
  assign q_c = {WC{bclk[2]}};
  assign q_d = {WD{bclk[3]}};
endmodule

// File: rtl/clkcfg_arbiter_chk.sv
module clkcfg_arbiter_chk #(
  parameter int DIV_W = 8,
  parameter int WA    = 4,
  parameter int WB    = 4,
  parameter int WC    = 2,
  parameter int WD    = 2
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic             init_q,
  input logic [4:0]       ctl_q,
  input logic [3:0]       en_q,
  input logic [1:0]       pin_a,
  input logic [1:0]       pin_b,
  input logic [DIV_W-1:0] fb_div,
  input logic [WA-1:0]    q_a,
  input logic [WB-1:0]    q_b,
  input logic [WC-1:0]    q_c,
  input logic [WD-1:0]    q_d
);
  AST_INIT_NEEDS_WRITE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !reg_we |=> !init_q); // R8

  AST_INIT_ALIGNS_ALL: assert property (@(posedge clk_ref) disable iff (!rst_n)
    init_q |=> (q_a == '0 && q_b == '0 && q_c == '0 && q_d == '0)); // R8

  AST_PIN_RELOAD_A: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!ctl_q[1] && pin_a != $past(pin_a)) |=> !q_a[0]); // R9

  AST_PIN_RELOAD_B: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!ctl_q[2] && pin_b != $past(pin_b)) |=> !q_b[0]); // R9

  AST_FB_REG_HELD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ctl_q[0] && !init_q && !(reg_we && reg_addr == 3'd0)) |=> $stable(fb_div)); // R3

  AST_DISABLED_STAYS_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ctl_q[4] && !en_q[3] && !q_d[0]) |=> !q_d[0]); // R11
endmodule

bind clkcfg_arbiter clkcfg_arbiter_chk #(
  .DIV_W(DIV_W), .WA(WA), .WB(WB), .WC(WC), .WD(WD)
) chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .init_q(init_q), .ctl_q(ctl_q), .en_q(en_q), .pin_a(pin_a), .pin_b(pin_b),
  .fb_div(fb_div), .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_d(q_d)
);

// File: tb/clkcfg_arbiter_test.sv
module clkcfg_arbiter_test;
  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, fb_div;
  logic [1:0] pin_fb = 2'd2, pin_a = 2'd0, pin_b = 2'd1, pin_c = 2'd2, pin_d = 2'd3;
  logic [3:0] q_a, q_b;
  logic [1:0] q_c, q_d;

  clkcfg_arbiter uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_fb(pin_fb), .pin_a(pin_a),
    .pin_b(pin_b), .pin_c(pin_c), .pin_d(pin_d), .fb_div(fb_div),
    .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_d(q_d)
  );

  always #5 clk_ref = ~clk_ref;

  typedef struct { string tag; int exp; } item_t;
  item_t exp_q[$];
  int    act_q[$];
  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int exp, input int act);
    exp_q.push_back('{tag, exp});
    act_q.push_back(act);
  endtask

  always @(negedge clk_ref) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t it;
      int a;
      it = exp_q.pop_front();
      a  = act_q.pop_front();
      tests++;
      if (a != it.exp) begin
        fails++;
        $display("FAIL %s: actual %0d expected %0d", it.tag, a, it.exp);
      end
    end
  end

  function automatic logic bq(input int b);
    case (b)
      0: return q_a[0];
      1: return q_b[0];
      2: return q_c[0];
      default: return q_d[0];
    endcase
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk_ref);
    @(negedge clk_ref);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_rise(input int b);
    int g = 0;
    while (bq(b) && g < 400) begin @(negedge clk_ref); g++; end
    while (!bq(b) && g < 400) begin @(negedge clk_ref); g++; end
  endtask

  task automatic period(input int b, output int t);
    wait_rise(b);
    t = 0;
    while (bq(b) && t < 400) begin @(negedge clk_ref); t++; end
    while (!bq(b) && t < 400) begin @(negedge clk_ref); t++; end
  endtask

  task automatic rises(output int r [4]);
    for (int b = 0; b < 4; b++) r[b] = -1;
    for (int t = 1; t <= 120; t++) begin
      @(negedge clk_ref);
      for (int b = 0; b < 4; b++) if (r[b] < 0 && bq(b)) r[b] = t;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v, p;
    int r [4];
    repeat (3) @(negedge clk_ref);
    rd(3'd0, v); chk("R1 ownership after reset", 0, v);
    rd(3'd1, v); chk("R1 enables after reset", 15, v);
    rd(3'd4, v); chk("R1 shadow after reset", 1, v);
    rd(3'd7, v); chk("R8 init reads 0", 0, v);
    chk("R4 feedback pin code 2", 16, fb_div);
    @(negedge clk_ref);
    rst_n = 1'b1;
    chk("R6 low at release", 0, {q_a, q_b, q_c, q_d});
    rises(r);
    chk("R6 first rise A", 1, r[0]);
    chk("R6 first rise B", 4, r[1]);
    chk("R6 first rise C", 12, r[2]);
    chk("R6 first rise D", 40, r[3]);
    period(0, p); chk("R5 period A", 2, p);
    period(1, p); chk("R5 R4 period B", 8, p);
    period(2, p); chk("R4 period C", 24, p);
    period(3, p); chk("R4 period D", 80, p);
    chk("R5 bank outputs equal", {4{q_b[0]}}, q_b);

    wr(3'd0, 8'b00010);
    wr(3'd3, 8'd3);
    rd(3'd3, v); chk("R7 shadow A readback", 3, v);
    period(0, p); chk("R7 A pending", 2, p);
    period(1, p); chk("R2 B still pin", 8, p);
    wr(3'd7, 8'd1);
    rd(3'd7, v); chk("R8 init reads 0 after write", 0, v);
    @(negedge clk_ref);
    rises(r);
    chk("R8 rise A", 3, r[0]);
    chk("R8 rise B", 4, r[1]);
    chk("R8 rise C", 12, r[2]);
    chk("R8 rise D", 40, r[3]);
    period(0, p); chk("R8 period A", 6, p);

    pin_a = 2'd3;
    period(0, p); chk("R3 A ignores pins", 6, p);
    wr(3'd4, 8'd7);
    wr(3'd7, 8'd1);
    period(1, p); chk("R3 B ignores shadow", 8, p);

    wr(3'd2, 8'd77);
    wr(3'd0, 8'b00011);
    chk("R7 feedback pending", 1, fb_div);
    wr(3'd7, 8'd1);
    @(negedge clk_ref);
    chk("R8 feedback loaded", 77, fb_div);
    pin_fb = 2'd0;
    @(negedge clk_ref);
    chk("R3 feedback ignores pins", 77, fb_div);

    wr(3'd0, 8'b01011);
    wr(3'd5, 8'd0);
    wr(3'd7, 8'd1);
    period(2, p); chk("R10 zero as one", 2, p);

    pin_b = 2'd0;
    @(negedge clk_ref);
    v = -1;
    for (int t = 1; t <= 20; t++) begin
      @(negedge clk_ref);
      if (v < 0 && q_b[0]) v = t;
    end
    chk("R9 B restart rise", 2, v);
    period(1, p); chk("R9 B new period", 4, p);

    wr(3'd0, 8'b11011);
    wr(3'd6, 8'd6);
    wr(3'd7, 8'd1);
    period(3, p); chk("R11 D period", 12, p);
    wait_rise(3);
    v = 1;
    wr(3'd1, 8'd7);
    while (q_d[0] && v < 100) begin v++; @(negedge clk_ref); end
    chk("R11 last pulse full", 6, v);
    v = 0;
    for (int t = 0; t < 60; t++) begin @(negedge clk_ref); if (q_d[0]) v++; end
    chk("R11 disabled low", 0, v);
    wr(3'd1, 8'd0);
    period(1, p); chk("R11 pin bank ignores enable", 4, p);
    wr(3'd1, 8'd15);
    wait_rise(3);
    v = 0;
    while (q_d[0] && v < 100) begin v++; @(negedge clk_ref); end
    chk("R11 resume full pulse", 6, v);

    repeat (3) @(negedge clk_ref);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule